// File: doc/BRIEF.md
# Monochrome Glyph Expander

This block turns a one-bit-per-pixel glyph bitmap into a stream of 32-bit colour pixel writes covering a destination rectangle. A setup command loads a foreground colour, a background colour and a transparency flag, which stay in force for all later drawing commands. A drawing command then gives the rectangle corners and the bitmap packing mode. The bitmap itself arrives as 32-bit words on a valid/ready word port. The words may be inline command payload or words brought in by a separate fetch agent.

For every pixel of the rectangle, in raster order, the block takes the next bitmap bit. A set bit produces a foreground write. A clear bit produces a background write, or no write at all when transparency is on. Writes leave as registered (x, y, colour) triples, at most one per clock. When the rectangle is complete, the block drops the unused bits of the current word. It then accepts one padding word if that is needed to make the payload an even number of words, and pulses `done_o`. Memory fetch and clipping belong to other blocks.

Top module: `glyph_expand`

## Requirements
- R1: A setup pulse (`setup_valid_i`) latches the background colour, foreground colour and transparency flag while the block is idle. A setup pulse while `busy_o` is high is ignored, and later writes keep the earlier colours.
- R2: A bitmap bit of 1 produces one write of the latched foreground colour at that pixel's coordinates.
- R3: A bitmap bit of 0 produces a write of the background colour when the transparency flag is 0, and no write (`pix_valid_o` stays low) when the flag is 1.
- R4: Pixels are visited left to right and then top to bottom, from (X1,Y1) inclusive to (X2,Y2) exclusive. Every write lies inside that rectangle.
- R5: Each word is read as four bytes, least significant byte first. Within a byte, bit 7 is the leftmost pixel and bit 0 the rightmost, so the word's bits are taken in the order 7..0, 15..8, 23..16, 31..24.
- R6: With `cmd_pack_i`=1 (byte packing), every row after the first starts at the next byte boundary of the bitmap. With `cmd_pack_i`=0 (bit packing), the rows follow one another with no gap.
- R7: After the last pixel, the remaining bits of the current word are dropped. If an odd number of words has been accepted, exactly one more word is accepted and discarded. The block accepts no further words.
- R8: `done_o` is high for exactly one cycle after the command's last write, and `busy_o` is already low in that cycle. A rectangle with X2<=X1 or Y2<=Y1 completes with no words and no writes.
- R9: A `cmd_valid_i` pulse while `busy_o` is high is ignored.
- R10: During and right after reset, `pix_valid_o`, `done_o`, `busy_o` and `word_ready_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid_i | input | 1 | Load colours and transparency flag |
| setup_bg_i | input | 32 | Background colour |
| setup_fg_i | input | 32 | Foreground colour |
| setup_transp_i | input | 1 | 1: clear bits write nothing |
| cmd_valid_i | input | 1 | Start a drawing command |
| cmd_x1_i | input | 16 | Left edge (inclusive) |
| cmd_y1_i | input | 16 | Top edge (inclusive) |
| cmd_x2_i | input | 16 | Right edge (exclusive) |
| cmd_y2_i | input | 16 | Bottom edge (exclusive) |
| cmd_pack_i | input | 1 | 1: byte packing, 0: bit packing |
| word_valid_i | input | 1 | Bitmap word available |
| word_data_i | input | 32 | Bitmap word |
| word_ready_o | output | 1 | Block takes the word this cycle |
| busy_o | output | 1 | Command in progress |
| pix_valid_o | output | 1 | Pixel write valid |
| pix_x_o | output | 16 | Pixel column |
| pix_y_o | output | 16 | Pixel row |
| pix_color_o | output | 32 | Pixel colour |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong bit pointer or row counter appears on the very next write as a wrong colour or a wrong coordinate. The pixel-by-pixel comparison against the reference queue catches it within one clock. A wrong word-parity count does not show in the pixels. It shows at the end of the command as a padding word that is taken or not taken, so the count of consumed words and the moment of `done_o` are checked for every command. Commands and setups issued while the block is busy must leave the current command unchanged, and the next command shows whether they left the latched colours untouched.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_TAIL
  } gx_state_t;
endpackage

// File: rtl/glyph_bit_pick.sv
module glyph_bit_pick #(
  parameter int WW = 32,
  parameter int PW = 5
) (
  input  logic [WW-1:0] word_i,
  input  logic [PW-1:0] idx_i,
  output logic          bit_o
);
  // Reorder so that position i of 'order' is the i-th pixel of the word:
  // bytes low to high, each byte from bit 7 down to bit 0.
  logic [WW-1:0] order;
  for (genvar i = 0; i < WW; i++) begin : g_map
    localparam int SRC = (i / 8) * 8 + 7 - (i % 8);
    assign order[i] = word_i[SRC];
  end
  assign bit_o = order[idx_i];
endmodule

// File: rtl/glyph_raster_walk.sv
module glyph_raster_walk #(
  parameter int CW = 16,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          pack_i,
  input  logic [CW-1:0] x1_i,
  input  logic [CW-1:0] y1_i,
  input  logic [CW-1:0] x2_i,
  input  logic [CW-1:0] y2_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic [PW-1:0] ptr_o,
  output logic          last_o,
  output logic          wrap_o
);
  logic [CW-1:0] x_q, y_q, x1_q, x2_q, y2_q;
  logic [PW-1:0] ptr_q;
  logic          pack_q;
  logic          x_end, y_end;
  logic [PW:0]   p_inc, p_rnd, p_nxt;

  assign x_end = ({1'b0, x_q} + {{CW{1'b0}}, 1'b1}) == {1'b0, x2_q};
  assign y_end = ({1'b0, y_q} + {{CW{1'b0}}, 1'b1}) == {1'b0, y2_q};

  assign p_inc = {1'b0, ptr_q} + {{PW{1'b0}}, 1'b1};
  assign p_rnd = {p_inc[PW:3] + {{(PW-3){1'b0}}, |p_inc[2:0]}, 3'b000};
  assign p_nxt = (pack_q && x_end) ? p_rnd : p_inc;

  assign last_o = x_end && y_end;
  assign wrap_o = p_nxt[PW];
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      x1_q   <= '0;
      x2_q   <= '0;
      y2_q   <= '0;
      ptr_q  <= '0;
      pack_q <= 1'b0;
    end else if (load_i) begin
      x_q    <= x1_i;
      y_q    <= y1_i;
      x1_q   <= x1_i;
      x2_q   <= x2_i;
      y2_q   <= y2_i;
      ptr_q  <= '0;
      pack_q <= pack_i;
    end else if (step_i) begin
      ptr_q <= p_nxt[PW-1:0];
      if (x_end) begin
        x_q <= x1_q;
        y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/glyph_pixel_out.sv
module glyph_pixel_out #(
  parameter int CW  = 16,
  parameter int CLW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire_i,
  input  logic           bit_i,
  input  logic           transp_i,
  input  logic [CLW-1:0] fg_i,
  input  logic [CLW-1:0] bg_i,
  input  logic [CW-1:0]  x_i,
  input  logic [CW-1:0]  y_i,
  output logic           valid_o,
  output logic [CW-1:0]  x_o,
  output logic [CW-1:0]  y_o,
  output logic [CLW-1:0] color_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      color_o <= '0;
    end else begin
      valid_o <= fire_i && (bit_i || !transp_i);
      if (fire_i) begin
        x_o     <= x_i;
        y_o     <= y_i;
        color_o <= bit_i ? fg_i : bg_i;
      end
    end
  end
endmodule

// File: rtl/glyph_expand.sv
module glyph_expand #(
  parameter int CW  = 16,
  parameter int WW  = 32,
  parameter int CLW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           setup_valid_i,
  input  logic [CLW-1:0] setup_bg_i,
  input  logic [CLW-1:0] setup_fg_i,
  input  logic           setup_transp_i,
  input  logic           cmd_valid_i,
  input  logic [CW-1:0]  cmd_x1_i,
  input  logic [CW-1:0]  cmd_y1_i,
  input  logic [CW-1:0]  cmd_x2_i,
  input  logic [CW-1:0]  cmd_y2_i,
  input  logic           cmd_pack_i,
  input  logic           word_valid_i,
  input  logic [WW-1:0]  word_data_i,
  output logic           word_ready_o,
  output logic           busy_o,
  output logic           pix_valid_o,
  output logic [CW-1:0]  pix_x_o,
  output logic [CW-1:0]  pix_y_o,
  output logic [CLW-1:0] pix_color_o,
  output logic           done_o
);
  import glyph_pkg::*;

  localparam int PW = $clog2(WW);

  gx_state_t      state_q;
  logic           odd_q;
  logic [CLW-1:0] bg_q, fg_q;
  logic           tr_q;
  logic [WW-1:0]  wbuf_q;
  logic           done_q;

  logic           load, step, empty_rect, last, wrap, cur_bit;
  logic [CW-1:0]  cur_x, cur_y;
  logic [PW-1:0]  ptr;

  assign empty_rect   = (cmd_x2_i <= cmd_x1_i) || (cmd_y2_i <= cmd_y1_i);
  assign load         = (state_q == ST_IDLE) && cmd_valid_i;
  assign step         = (state_q == ST_RUN);
  assign word_ready_o = (state_q == ST_FETCH) || ((state_q == ST_TAIL) && odd_q);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;

  glyph_raster_walk #(.CW(CW), .PW(PW)) walk_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .step_i (step),
    .pack_i (cmd_pack_i),
    .x1_i   (cmd_x1_i),
    .y1_i   (cmd_y1_i),
    .x2_i   (cmd_x2_i),
    .y2_i   (cmd_y2_i),
    .x_o    (cur_x),
    .y_o    (cur_y),
    .ptr_o  (ptr),
    .last_o (last),
    .wrap_o (wrap)
  );

  glyph_bit_pick #(.WW(WW), .PW(PW)) pick_i (
    .word_i (wbuf_q),
    .idx_i  (ptr),
    .bit_o  (cur_bit)
  );

  glyph_pixel_out #(.CW(CW), .CLW(CLW)) out_i (
    .clk      (clk),
    .rst      (rst),
    .fire_i   (step),
    .bit_i    (cur_bit),
    .transp_i (tr_q),
    .fg_i     (fg_q),
    .bg_i     (bg_q),
    .x_i      (cur_x),
    .y_i      (cur_y),
    .valid_o  (pix_valid_o),
    .x_o      (pix_x_o),
    .y_o      (pix_y_o),
    .color_o  (pix_color_o)
  );

  // Colour setup is taken only between commands.
  always_ff @(posedge clk) begin
    if (rst) begin
      bg_q <= '0;
      fg_q <= '0;
      tr_q <= 1'b0;
    end else if (setup_valid_i && (state_q == ST_IDLE)) begin
      bg_q <= setup_bg_i;
      fg_q <= setup_fg_i;
      tr_q <= setup_transp_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      odd_q   <= 1'b0;
      wbuf_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            odd_q   <= 1'b0;
            state_q <= empty_rect ? ST_TAIL : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (word_valid_i) begin
            wbuf_q  <= word_data_i;
            odd_q   <= ~odd_q;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last) begin
            state_q <= ST_TAIL;
          end else if (wrap) begin
            state_q <= ST_FETCH;
          end
        end
        ST_TAIL: begin
          if (odd_q) begin
            if (word_valid_i) begin
              odd_q <= 1'b0;
            end
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/glyph_expand_chk.sv
module glyph_expand_chk #(
  parameter int CW  = 16,
  parameter int CLW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           setup_valid_i,
  input logic [CLW-1:0] setup_fg_i,
  input logic           setup_transp_i,
  input logic           cmd_valid_i,
  input logic [CW-1:0]  cmd_x1_i,
  input logic [CW-1:0]  cmd_y1_i,
  input logic [CW-1:0]  cmd_x2_i,
  input logic [CW-1:0]  cmd_y2_i,
  input logic           word_valid_i,
  input logic           word_ready_o,
  input logic           busy_o,
  input logic           pix_valid_o,
  input logic [CW-1:0]  pix_x_o,
  input logic [CW-1:0]  pix_y_o,
  input logic [CLW-1:0] pix_color_o,
  input logic           done_o
);
  logic [CW-1:0]  rx1, ry1, rx2, ry2;
  logic [CLW-1:0] fg_c;
  logic           tr_c;
  logic           odd_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx1 <= '0; ry1 <= '0; rx2 <= '0; ry2 <= '0;
      fg_c <= '0; tr_c <= 1'b0; odd_c <= 1'b0;
    end else begin
      if (cmd_valid_i && !busy_o) begin
        rx1 <= cmd_x1_i; ry1 <= cmd_y1_i; rx2 <= cmd_x2_i; ry2 <= cmd_y2_i;
        odd_c <= 1'b0;
      end else if (word_valid_i && word_ready_o) begin
        odd_c <= ~odd_c;
      end
      if (setup_valid_i && !busy_o) begin
        fg_c <= setup_fg_i;
        tr_c <= setup_transp_i;
      end
    end
  end

  AST_TRANSP_ONLY_FG: assert property (@(posedge clk) disable iff (rst)
    (pix_valid_o && tr_c) |-> (pix_color_o == fg_c)); // R3
  AST_PIX_IN_RECT: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> (pix_x_o >= rx1 && pix_x_o < rx2 && pix_y_o >= ry1 && pix_y_o < ry2)); // R4
  AST_EVEN_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !odd_c); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!pix_valid_o && !word_ready_o)); // R9
endmodule

bind glyph_expand glyph_expand_chk #(.CW(CW), .CLW(CLW)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .setup_valid_i  (setup_valid_i),
  .setup_fg_i     (setup_fg_i),
  .setup_transp_i (setup_transp_i),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_x1_i       (cmd_x1_i),
  .cmd_y1_i       (cmd_y1_i),
  .cmd_x2_i       (cmd_x2_i),
  .cmd_y2_i       (cmd_y2_i),
  .word_valid_i   (word_valid_i),
  .word_ready_o   (word_ready_o),
  .busy_o         (busy_o),
  .pix_valid_o    (pix_valid_o),
  .pix_x_o        (pix_x_o),
  .pix_y_o        (pix_y_o),
  .pix_color_o    (pix_color_o),
  .done_o         (done_o)
);

// File: tb/glyph_expand_tb_top.sv
`timescale 1ns/1ps
module glyph_expand_tb_top;
  localparam int CW = 16, WW = 32, CLW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic setup_valid = 0, setup_transp = 0, cmd_valid = 0, cmd_pack = 0;
  logic [CLW-1:0] setup_bg = '0, setup_fg = '0;
  logic [CW-1:0] cmd_x1 = '0, cmd_y1 = '0, cmd_x2 = '0, cmd_y2 = '0;
  logic word_valid = 0;
  logic [WW-1:0] word_data = '0;
  logic word_ready, busy, pix_valid, done;
  logic [CW-1:0] pix_x, pix_y;
  logic [CLW-1:0] pix_color;

  always #4 clk = ~clk;

  glyph_expand #(.CW(CW), .WW(WW), .CLW(CLW)) dut_i (
    .clk(clk), .rst(rst),
    .setup_valid_i(setup_valid), .setup_bg_i(setup_bg), .setup_fg_i(setup_fg),
    .setup_transp_i(setup_transp),
    .cmd_valid_i(cmd_valid), .cmd_x1_i(cmd_x1), .cmd_y1_i(cmd_y1),
    .cmd_x2_i(cmd_x2), .cmd_y2_i(cmd_y2), .cmd_pack_i(cmd_pack),
    .word_valid_i(word_valid), .word_data_i(word_data), .word_ready_o(word_ready),
    .busy_o(busy), .pix_valid_o(pix_valid), .pix_x_o(pix_x), .pix_y_o(pix_y),
    .pix_color_o(pix_color), .done_o(done)
  );

  typedef struct { int x; int y; logic [31:0] c; } pix_t;

  int errs = 0, checks = 0, consumed = 0, done_cnt = 0;
  logic [31:0] feed_q[$];
  pix_t exp_q[$];
  string cur_tag = "R10";
  logic [31:0] m_bg = '0, m_fg = '0;
  bit m_tr = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Word feeder: offers queued words; a word leaves the queue on handshake.
  initial begin
    forever begin
      bit hs;
      @(negedge clk);
      hs = word_valid && word_ready;
      @(posedge clk); #1;
      if (hs) begin
        void'(feed_q.pop_front());
        consumed++;
      end
      if (feed_q.size() > 0) begin
        word_valid = 1'b1;
        word_data  = feed_q[0];
      end else begin
        word_valid = 1'b0;
      end
    end
  end

  // Output comparison on every clock.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pix_valid) begin
          if (exp_q.size() == 0) begin
            chk(0, cur_tag, "unexpected write at x", longint'(pix_x), 0);
          end else begin
            pix_t p;
            p = exp_q.pop_front();
            checks++;
            if (pix_x != p.x[CW-1:0] || pix_y != p.y[CW-1:0] || pix_color != p.c) begin
              errs++;
              $display("FAIL %s pixel: actual=(%0d,%0d,%h) expected=(%0d,%0d,%h)",
                       cur_tag, pix_x, pix_y, pix_color, p.x, p.y, p.c);
            end
          end
        end
        if (done) begin
          done_cnt++;
          chk(!busy, "R8", "busy during done", longint'(busy), 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic do_setup(logic [31:0] bg, logic [31:0] fg, bit tr);
    @(posedge clk); #1;
    setup_valid = 1; setup_bg = bg; setup_fg = fg; setup_transp = tr;
    @(posedge clk); #1;
    setup_valid = 0;
    m_bg = bg; m_fg = fg; m_tr = tr;
  endtask

  // Builds the expected writes from the requirements, runs one command.
  task automatic run_cmd(int x1, int y1, int x2, int y2, bit pack, string tag, int junk_at);
    int p, lastp, nwords, d0;
    p = 0; lastp = -1;
    for (int y = y1; y < y2; y++) begin
      for (int x = x1; x < x2; x++) begin
        int k;
        logic [31:0] w;
        k = p % 32;
        w = (p / 32 < feed_q.size()) ? feed_q[p / 32] : 32'h0;
        if (w[(k / 8) * 8 + 7 - (k % 8)]) exp_q.push_back('{x, y, m_fg});
        else if (!m_tr) exp_q.push_back('{x, y, m_bg});
        lastp = p;
        p++;
      end
      if (pack) p = ((p + 7) / 8) * 8;
    end
    nwords = (lastp < 0) ? 0 : (lastp / 32) + 1;
    nwords = nwords + (nwords % 2);
    cur_tag = tag;
    consumed = 0;
    d0 = done_cnt;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_x1 = CW'(x1); cmd_y1 = CW'(y1);
    cmd_x2 = CW'(x2); cmd_y2 = CW'(y2); cmd_pack = pack;
    @(posedge clk); #1;
    cmd_valid = 0;
    if (junk_at > 0) begin
      repeat (junk_at) @(posedge clk);
      #1;
      cmd_valid = 1; cmd_x1 = 0; cmd_y1 = 0; cmd_x2 = 3; cmd_y2 = 3; cmd_pack = ~pack;
      setup_valid = 1; setup_bg = 32'h1234_5678; setup_fg = 32'h8765_4321; setup_transp = ~m_tr;
      @(posedge clk); #1;
      cmd_valid = 0; setup_valid = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, "writes missing", exp_q.size(), 0);
    chk(consumed == nwords, "R7", "words consumed", consumed, nwords);
    chk(feed_q.size() == 0, "R7", "words left over", feed_q.size(), 0);
    chk(done_cnt == d0 + 1, "R8", "done pulses", done_cnt - d0, 1);
    exp_q.delete();
    feed_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!pix_valid && !done && !busy && !word_ready, "R10", "outputs in reset",
        {pix_valid, done, busy, word_ready}, 0);
    @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    chk(!pix_valid && !done && !busy && !word_ready, "R10", "outputs after reset",
        {pix_valid, done, busy, word_ready}, 0);

    // R2 R3 R4 R5: opaque, bit packed, one data word plus pad.
    do_setup(32'hAAAA_0001, 32'h5555_FFFE, 0);
    feed_q = '{32'hF0C3_A51E, 32'h0};
    run_cmd(2, 3, 10, 5, 0, "R2 R3 R4 R5", 0);

    // R3: transparent, same bitmap.
    do_setup(32'hDEAD_BEEF, 32'h0BAD_F00D, 1);
    feed_q = '{32'hF0C3_A51E, 32'h0};
    run_cmd(2, 3, 10, 5, 0, "R3", 0);

    // R6: byte packing, 5 wide: rows begin at bits 0, 8, 16, 24.
    do_setup(32'h0000_00BB, 32'hFF00_0000, 0);
    feed_q = '{32'h97A5_3C6E, 32'hFFFF_FFFF};
    run_cmd(0, 0, 5, 4, 1, "R6", 0);

    // R6 R7: byte packing, 12 wide over several words, pad needed.
    feed_q = '{32'h1357_9BDF, 32'h2468_ACE0, 32'hF0E1_D2C3, 32'h0};
    run_cmd(100, 200, 112, 206, 1, "R6 R7", 0);

    // R6 R7: bit packing, 7x9 = 63 bits, exactly two words, no pad.
    feed_q = '{32'hC0FF_EE11, 32'h7E57_D00D};
    run_cmd(40, 1, 47, 10, 0, "R6 R7", 0);

    // R7: single pixel, rest of the word dropped, pad taken.
    feed_q = '{32'h0000_0080, 32'hFFFF_FFFF};
    run_cmd(9, 9, 10, 10, 0, "R5 R7", 0);

    // R8: empty rectangle, no words, no writes.
    run_cmd(5, 5, 5, 8, 0, "R8", 0);

    // R1 R9: command and setup pulses while busy are ignored.
    do_setup(32'h0101_0101, 32'hFEFE_FEFE, 0);
    feed_q = '{32'h8421_1248, 32'h0F0F_33CC};
    run_cmd(0, 10, 20, 13, 0, "R9", 5);
    feed_q = '{32'h00FF_AA55, 32'h0};
    run_cmd(3, 3, 7, 5, 0, "R1", 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule